// File: doc/BRIEF.md
# Logical OR Execute Unit

This unit is the execute slice for the logical OR opcode family of a general-purpose integer core. Each issued operation arrives with its opcode byte, the three-bit reg field of the addressing byte, the operand size, the first operand, the second operand (a register value) and a raw 32-bit immediate that has already been extracted from the instruction stream. The unit decides which of the two sources feeds the OR and how the immediate is widened. It then computes the result at the active operand size, together with the status flags, a mask that marks undefined flags, a write-back enable and an illegal-form indication.

A control module decodes the opcode into a small set of strobes: a legal bit, an immediate mode and an effective size. A datapath module builds the second operand, evaluates one OR lane per operand size, picks the active lane and registers the outcome. The result is ready one clock after issue. Operand fetch, bus locking, segmentation and fault delivery are handled elsewhere. The unit is only told, through two flags, whether the destination and the source are memory operands.

Top module: `orx_exec_top`

## Requirements
- R1: Every output is registered. An operation issued with `issueVld` high at a clock edge appears with `resVld` high after the next edge. A cycle with no issue gives `resVld`, `wrEn` and `illegal` low. Reset clears `resVld` and `wrEn`.
- R2: The result is the bitwise OR of both operands: a bit is 0 only when both input bits are 0. It is computed at the effective size (`opSize` 0=8, 1=16, 2=32, 3=64 bits), and all result bits above that size are 0.
- R3: Opcodes 0x08 and 0x0A are byte forms whose effective size is 8 bits whatever `opSize` says. Opcodes 0x09 and 0x0B use `opSize`. All four OR `srcA` with `srcB`.
- R4: Opcode 0x0C ORs `srcA` with `imm[7:0]` at 8 bits. Opcode 0x0D uses `opSize`: at 16 bits it takes `imm[15:0]`, at 32 bits the full immediate, and at 64 bits the immediate sign-extended from bit 31.
- R5: With reg field 1, opcode 0x80 ORs `imm[7:0]` at 8 bits. Opcode 0x81 widens the immediate as 0x0D does. Opcode 0x83 sign-extends `imm[7:0]` from bit 7 to the size given by `opSize`.
- R6: The flag vector is {OF, SF, ZF, AF, PF, CF} on bits 5..0. For a legal operation OF, CF and AF are 0, SF is the top bit of the result at the effective size, ZF is 1 when the sized result is 0, and PF is 1 when bits 7..0 of the result hold an even number of ones.
- R7: A legal operation gives `undefMask` = 6'b000100, which marks AF as undefined, and `wrEn` = 1.
- R8: The form is illegal when any of these holds: opcode 0x80, 0x81 or 0x83 with a reg field other than 1; an opcode outside the family; a wide form (0x09, 0x0B, 0x0D, 0x81, 0x83) with `opSize` 0; or `memDst` and `memSrc` both set. An illegal form gives `illegal` = 1, `wrEn` = 0, and zero result, flags and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| issueVld | input | 1 | An operation is presented this cycle |
| opByte | input | 8 | Primary opcode byte |
| modrmReg | input | 3 | Reg field of the addressing byte |
| opSize | input | 2 | Operand size: 0=8, 1=16, 2=32, 3=64 bits |
| memDst | input | 1 | First operand is a memory location |
| memSrc | input | 1 | Second operand is a memory location |
| srcA | input | 64 | First operand value |
| srcB | input | 64 | Second operand register value |
| imm | input | 32 | Raw immediate, low bits aligned |
| resVld | output | 1 | Outputs hold a completed operation |
| resData | output | 64 | Zero-extended result |
| wrEn | output | 1 | Write the result back |
| flags | output | 6 | {OF, SF, ZF, AF, PF, CF} |
| undefMask | output | 6 | Marks undefined flags, same bit order |
| illegal | output | 1 | Illegal opcode form |

## Verification
A wrong decode strobe always shows up in the single output word of the next cycle. A misread size leaks bits above the size or moves SF. A wrong immediate mode breaks the upper bytes of the sign-extended cases. A missed illegal form raises `wrEn` where it must stay low. There is no state that survives an operation, so each fault is visible exactly one clock after the stimulus that exposes it. Comparing every cycle against a behavioural model therefore points straight at the operation at fault.

// File: rtl/orx_pkg.sv
package orx_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_QWORD = 2'd3
  } opSize_e;

  typedef enum logic [1:0] {
    IMM_NONE   = 2'd0,
    IMM_ZX8    = 2'd1,
    IMM_SX8    = 2'd2,
    IMM_NATIVE = 2'd3
  } immMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     legal;
    immMode_e immMode;
    opSize_e  effSize;
  } ctrlStrobe_t;

  localparam int FLAG_N  = 6;
  localparam int FL_OF   = 5;
  localparam int FL_SF   = 4;
  localparam int FL_ZF   = 3;
  localparam int FL_AF   = 2;
  localparam int FL_PF   = 1;
  localparam int FL_CF   = 0;

  localparam logic [7:0] OPC_RM8_R  = 8'h08;
  localparam logic [7:0] OPC_RMV_R  = 8'h09;
  localparam logic [7:0] OPC_R8_RM  = 8'h0A;
  localparam logic [7:0] OPC_RV_RM  = 8'h0B;
  localparam logic [7:0] OPC_ACC8   = 8'h0C;
  localparam logic [7:0] OPC_ACCV   = 8'h0D;
  localparam logic [7:0] OPC_GRP8   = 8'h80;
  localparam logic [7:0] OPC_GRPV   = 8'h81;
  localparam logic [7:0] OPC_GRPSX  = 8'h83;
  localparam logic [2:0] GRP_OR_SEL = 3'd1;

endpackage

// File: rtl/orx_ctrl.sv
module orx_ctrl
  import orx_pkg::*;
(
  input  logic [7:0]  opByte,
  input  logic [2:0]  modrmReg,
  input  logic [1:0]  opSize,
  input  logic        memDst,
  input  logic        memSrc,
  output ctrlStrobe_t strobe
);

  logic    wideOk;
  logic    grpSel;
  logic    formOk;
  opSize_e reqSize;

  assign reqSize = opSize_e'(opSize);
  assign wideOk  = (reqSize != SZ_BYTE);
  assign grpSel  = (modrmReg == GRP_OR_SEL);

  always_comb begin
    formOk          = 1'b0;
    strobe.immMode  = IMM_NONE;
    strobe.effSize  = SZ_BYTE;
    unique case (opByte)
      OPC_RM8_R, OPC_R8_RM: begin
        formOk = 1'b1;
      end
      OPC_RMV_R, OPC_RV_RM: begin
        formOk         = wideOk;
        strobe.effSize = reqSize;
      end
      OPC_ACC8: begin
        formOk         = 1'b1;
        strobe.immMode = IMM_ZX8;
      end
      OPC_ACCV: begin
        formOk         = wideOk;
        strobe.immMode = IMM_NATIVE;
        strobe.effSize = reqSize;
      end
      OPC_GRP8: begin
        formOk         = grpSel;
        strobe.immMode = IMM_ZX8;
      end
      OPC_GRPV: begin
        formOk         = grpSel && wideOk;
        strobe.immMode = IMM_NATIVE;
        strobe.effSize = reqSize;
      end
      OPC_GRPSX: begin
        formOk         = grpSel && wideOk;
        strobe.immMode = IMM_SX8;
        strobe.effSize = reqSize;
      end
      default: begin
        formOk = 1'b0;
      end
    endcase
    strobe.legal = formOk && !(memDst && memSrc);
  end

endmodule

// File: rtl/orx_datapath.sv
module orx_datapath
  import orx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueVld,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  imm,
  output logic              resVld,
  output logic [DATA_W-1:0] resData,
  output logic              wrEn,
  output logic [FLAG_N-1:0] flags,
  output logic [FLAG_N-1:0] undefMask,
  output logic              illegal
);

  localparam int LANES = $clog2(DATA_W / 8) + 1;

  logic [DATA_W-1:0] operB;
  logic [DATA_W-1:0] rawOr;
  logic [DATA_W-1:0] laneRes  [LANES];
  logic              laneSign [LANES];
  logic [DATA_W-1:0] selRes;
  logic              selSign;
  logic [FLAG_N-1:0] nxtFlags;

  always_comb begin
    unique case (strobe.immMode)
      IMM_ZX8:    operB = {{(DATA_W-8){1'b0}}, imm[7:0]};
      IMM_SX8:    operB = {{(DATA_W-8){imm[7]}}, imm[7:0]};
      IMM_NATIVE: operB = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
      default:    operB = srcB;
    endcase
  end

  assign rawOr = srcA | operB;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LW = 8 << k;
    if (LW >= DATA_W) begin : g_full
      assign laneRes[k] = rawOr;
    end else begin : g_part
      assign laneRes[k] = {{(DATA_W-LW){1'b0}}, rawOr[LW-1:0]};
    end
    assign laneSign[k] = rawOr[LW-1];
  end

  always_comb begin
    selRes  = laneRes[0];
    selSign = laneSign[0];
    for (int k = 0; k < LANES; k++) begin
      if (int'(strobe.effSize) == k) begin
        selRes  = laneRes[k];
        selSign = laneSign[k];
      end
    end
  end

  always_comb begin
    nxtFlags        = '0;
    nxtFlags[FL_SF] = selSign;
    nxtFlags[FL_ZF] = (selRes == '0);
    nxtFlags[FL_PF] = ~^selRes[7:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resVld    <= 1'b0;
      resData   <= '0;
      wrEn      <= 1'b0;
      flags     <= '0;
      undefMask <= '0;
      illegal   <= 1'b0;
    end else begin
      resVld    <= issueVld;
      resData   <= '0;
      wrEn      <= 1'b0;
      flags     <= '0;
      undefMask <= '0;
      illegal   <= 1'b0;
      if (issueVld) begin
        if (strobe.legal) begin
          resData          <= selRes;
          wrEn             <= 1'b1;
          flags            <= nxtFlags;
          undefMask[FL_AF] <= 1'b1;
        end else begin
          illegal <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/orx_exec_top.sv
module orx_exec_top
  import orx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueVld,
  input  logic [7:0]        opByte,
  input  logic [2:0]        modrmReg,
  input  logic [1:0]        opSize,
  input  logic              memDst,
  input  logic              memSrc,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  imm,
  output logic              resVld,
  output logic [DATA_W-1:0] resData,
  output logic              wrEn,
  output logic [5:0]        flags,
  output logic [5:0]        undefMask,
  output logic              illegal
);

  ctrlStrobe_t strobe;

  orx_ctrl u_ctrl (
    .opByte   (opByte),
    .modrmReg (modrmReg),
    .opSize   (opSize),
    .memDst   (memDst),
    .memSrc   (memSrc),
    .strobe   (strobe)
  );

  orx_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .issueVld  (issueVld),
    .strobe    (strobe),
    .srcA      (srcA),
    .srcB      (srcB),
    .imm       (imm),
    .resVld    (resVld),
    .resData   (resData),
    .wrEn      (wrEn),
    .flags     (flags),
    .undefMask (undefMask),
    .illegal   (illegal)
  );

endmodule

// File: rtl/orx_exec_chk.sv
module orx_exec_chk (
  input logic        clk,
  input logic        rstN,
  input logic        issueVld,
  input logic [1:0]  opSize,
  input logic        resVld,
  input logic [63:0] resData,
  input logic        wrEn,
  input logic [5:0]  flags,
  input logic [5:0]  undefMask,
  input logic        illegal
);

  // R1
  issue_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueVld |=> resVld);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resVld |-> (!wrEn && !illegal));

  // R6
  of_cf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (flags[5] == 1'b0 && flags[0] == 1'b0 && flags[2] == 1'b0));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (flags[3] == (resData == 64'd0)));

  // R7
  undef_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (undefMask == 6'b000100));

  // R8
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!wrEn && resData == 64'd0 && flags == 6'd0 && undefMask == 6'd0));

  // R1
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrEn, illegal}));

  // R2
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueVld && opSize == 2'd0) |=> (resData[63:8] == 56'd0));

endmodule

bind orx_exec_top orx_exec_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .issueVld  (issueVld),
  .opSize    (opSize),
  .resVld    (resVld),
  .resData   (resData),
  .wrEn      (wrEn),
  .flags     (flags),
  .undefMask (undefMask),
  .illegal   (illegal)
);

// File: tb/orx_exec_tb.sv
module orx_exec_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueVld = 1'b0;
  logic [7:0]  opByte = '0;
  logic [2:0]  modrmReg = '0;
  logic [1:0]  opSize = '0;
  logic        memDst = 1'b0;
  logic        memSrc = 1'b0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic [31:0] imm = '0;
  logic        resVld;
  logic [63:0] resData;
  logic        wrEn;
  logic [5:0]  flags;
  logic [5:0]  undefMask;
  logic        illegal;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  orx_exec_top dut_i (
    .clk(clk), .rstN(rstN), .issueVld(issueVld), .opByte(opByte),
    .modrmReg(modrmReg), .opSize(opSize), .memDst(memDst), .memSrc(memSrc),
    .srcA(srcA), .srcB(srcB), .imm(imm), .resVld(resVld), .resData(resData),
    .wrEn(wrEn), .flags(flags), .undefMask(undefMask), .illegal(illegal)
  );

  // pending expectation for the next sample
  logic        pVld = 1'b0;
  logic        pIll;
  logic [63:0] pData;
  logic [5:0]  pFl;
  logic [5:0]  pUm;
  string       pTag = "R1";

  task automatic model(input logic [7:0] op, input logic [2:0] rg,
                       input logic [1:0] sz, input logic [63:0] a,
                       input logic [63:0] b, input logic [31:0] im,
                       input logic md, input logic ms);
    int w;
    logic bad;
    logic [63:0] bv, mask, r;
    logic [63:0] sx32, sx8;
    sx32 = {{32{im[31]}}, im};
    sx8  = {{56{im[7]}}, im[7:0]};
    w = 8 << sz;
    bad = 1'b0;
    bv = b;
    case (op)
      8'h08, 8'h0A: w = 8;
      8'h09, 8'h0B: bad = (sz == 0);
      8'h0C: begin w = 8; bv = {56'd0, im[7:0]}; end
      8'h0D: begin bad = (sz == 0); bv = sx32; end
      8'h80: begin w = 8; bv = {56'd0, im[7:0]}; bad = (rg != 1); end
      8'h81: begin bv = sx32; bad = (rg != 1) || (sz == 0); end
      8'h83: begin bv = sx8; bad = (rg != 1) || (sz == 0); end
      default: bad = 1'b1;
    endcase
    if (md && ms) bad = 1'b1;
    mask = (w == 64) ? ~64'd0 : ((64'd1 << w) - 64'd1);
    r = (a | bv) & mask;
    pVld = 1'b1;
    if (bad) begin
      pIll = 1'b1; pData = '0; pFl = '0; pUm = '0;
    end else begin
      pIll  = 1'b0;
      pData = r;
      pFl   = {1'b0, r[w-1], (r == 64'd0), 1'b0, ~^r[7:0], 1'b0};
      pUm   = 6'b000100;
    end
  endtask

  task automatic checkNow();
    testCount++;
    if (resVld !== pVld) begin
      failCount++;
      $display("FAIL %s resVld actual %b expected %b", pTag, resVld, pVld);
    end else if (!pVld) begin
      if (wrEn !== 1'b0 || illegal !== 1'b0) begin
        failCount++;
        $display("FAIL %s idle wrEn/illegal actual %b%b expected 00", pTag, wrEn, illegal);
      end
    end else begin
      if (illegal !== pIll || wrEn !== !pIll || resData !== pData ||
          flags !== pFl || undefMask !== pUm) begin
        failCount++;
        $display("FAIL %s actual ill=%b we=%b data=%h fl=%b um=%b expected ill=%b we=%b data=%h fl=%b um=%b",
                 pTag, illegal, wrEn, resData, flags, undefMask,
                 pIll, !pIll, pData, pFl, pUm);
      end
    end
  endtask

  task automatic issue(input string tag, input logic [7:0] op, input logic [2:0] rg,
                       input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b,
                       input logic [31:0] im, input logic md, input logic ms);
    @(negedge clk);
    checkNow();
    issueVld = 1'b1; opByte = op; modrmReg = rg; opSize = sz;
    srcA = a; srcB = b; imm = im; memDst = md; memSrc = ms;
    pTag = tag;
    model(op, rg, sz, a, b, im, md, ms);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    checkNow();
    issueVld = 1'b0;
    srcA = 64'hFFFF_FFFF_FFFF_FFFF; opByte = 8'h0D; opSize = 2'd3;
    pTag = tag;
    pVld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    testCount++;
    if (resVld !== 1'b0 || wrEn !== 1'b0) begin
      failCount++;
      $display("FAIL R1 reset actual vld=%b we=%b expected 00", resVld, wrEn);
    end
    rstN = 1'b1;
    pVld = 1'b0;
    idle("R1");
    // R3 byte forms ignore opSize, R2 upper bits zero
    issue("R3", 8'h08, 3'd5, 2'd3, 64'hDEAD_BEEF_1234_12F0, 64'hFFFF_0000_0000_000F, 32'h0, 1'b1, 1'b0);
    issue("R3", 8'h0A, 3'd0, 2'd2, 64'h0, 64'h0, 32'hFF, 1'b0, 1'b1);
    issue("R2", 8'h09, 3'd0, 2'd1, 64'hAAAA_0000_0000_8000, 64'h5555_0000_0000_0001, 32'h0, 1'b0, 1'b0);
    issue("R6", 8'h0B, 3'd0, 2'd2, 64'hFFFF_FFFF_0000_0000, 64'h0, 32'h0, 1'b0, 1'b0);
    issue("R2", 8'h09, 3'd0, 2'd3, 64'h8000_0000_0000_0300, 64'h0000_00F0_0000_0000, 32'h0, 1'b1, 1'b0);
    idle("R1");
    // R4 accumulator immediates
    issue("R4", 8'h0C, 3'd0, 2'd3, 64'h0000_0000_0000_0001, 64'hFF, 32'hFFFF_FF80, 1'b0, 1'b0);
    issue("R4", 8'h0D, 3'd0, 2'd1, 64'h0, 64'h0, 32'hFFFF_8001, 1'b0, 1'b0);
    issue("R4", 8'h0D, 3'd0, 2'd3, 64'h1, 64'h0, 32'h8000_0000, 1'b0, 1'b0);
    issue("R4", 8'h0D, 3'd0, 2'd2, 64'h1, 64'h0, 32'h8000_0000, 1'b0, 1'b0);
    // R5 immediate group
    issue("R5", 8'h80, 3'd1, 2'd3, 64'h0000_0000_0000_0300, 64'h0, 32'h0000_0033, 1'b1, 1'b0);
    issue("R5", 8'h81, 3'd1, 2'd3, 64'h0, 64'h0, 32'h7FFF_FFFF, 1'b0, 1'b0);
    issue("R5", 8'h83, 3'd1, 2'd1, 64'h0, 64'h0, 32'h0000_00FF, 1'b0, 1'b0);
    issue("R5", 8'h83, 3'd1, 2'd3, 64'h0, 64'h0, 32'h0000_0080, 1'b0, 1'b0);
    issue("R5", 8'h83, 3'd1, 2'd2, 64'h0000_0000_0000_0000, 64'h0, 32'hFFFF_FF00, 1'b0, 1'b0);
    // R6 zero result, R7 mask
    issue("R7", 8'h83, 3'd1, 2'd1, 64'hFFFF_FFFF_FFFF_0000, 64'h0, 32'h0000_0000, 1'b0, 1'b0);
    // R8 illegal forms
    issue("R8", 8'h81, 3'd0, 2'd2, 64'h5, 64'h5, 32'h5, 1'b0, 1'b0);
    issue("R8", 8'h83, 3'd7, 2'd3, 64'h5, 64'h5, 32'h5, 1'b0, 1'b0);
    issue("R8", 8'h00, 3'd1, 2'd3, 64'h5, 64'h5, 32'h5, 1'b0, 1'b0);
    issue("R8", 8'h09, 3'd0, 2'd0, 64'h5, 64'h5, 32'h5, 1'b0, 1'b0);
    issue("R8", 8'h08, 3'd0, 2'd0, 64'h5, 64'h5, 32'h5, 1'b1, 1'b1);
    issue("R8", 8'h80, 3'd2, 2'd0, 64'h5, 64'h5, 32'h5, 1'b0, 1'b0);
    issue("R6", 8'h0B, 3'd0, 2'd3, 64'h0000_0000_0000_0007, 64'h0, 32'h0, 1'b0, 1'b1);
    idle("R1");
    idle("R1");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule